// File: doc/BRIEF.md
# Two-Phase Driver Impedance Calibration Controller

This block sets the strength of an output driver by running two digital feedback loops, one after the other. Each loop holds a 6-bit binary code. It moves that code one step up or down per decision, driven by a single comparator bit from the analog side. The comparators, replica legs and divider nodes sit outside the block. They reach it only as the two compare inputs, `cmp_pu_i` and `cmp_pd_i`.

A rising edge on the enable input starts a run. The pull-up code is trimmed first, against the external half-termination reference. When that loop dithers about its target, its code is frozen. The pull-down loop then trims the second code against the node that the frozen pull-up code sets. A reference-select output tells the analog side which comparison is active. A done flag reports that both codes are frozen. Comparator inputs are sampled only on every fourth clock, which gives the analog nodes time to settle after each step.

Top module: `imp_cal_seq`

## Requirements
- R1: After reset, both codes read 32, `done_o` is 0 and `ref_sel_o` is 0.
- R2: A rising edge of `cal_en_i` (sampled high after being low at the previous clock edge) reloads both codes to 32 at that edge and starts the pull-up phase. During the pull-up phase `ref_sel_o` is 0.
- R3: Decisions occur only on every fourth clock edge counted from the start edge, and from the edge that begins the pull-down phase. Codes change on no other edge.
- R4: In the active loop, a comparator bit of 1 raises the code by one and a bit of 0 lowers it by one. The code saturates at 63 and at 0 and never wraps.
- R5: A loop is settled on the decision at which the comparator bit has differed from the previous decision's bit on four consecutive decisions. That decision does not step the code; the code freezes at its current value.
- R6: When the pull-up loop settles, `ref_sel_o` becomes 1 (1 = pull-down comparison active) and the pull-down loop runs from code 32 using `cmp_pd_i`. The pull-up code stays frozen.
- R7: When the pull-down loop settles, `done_o` becomes 1 and `ref_sel_o` returns to 0. Both codes then hold regardless of the comparator inputs.
- R8: With `cal_en_i` low at a clock edge, the block is idle after that edge: `done_o` is 0, `ref_sel_o` is 0 and both codes hold their values.
- R9: A later rising edge of `cal_en_i` restarts the full sequence from R2, whether the previous run finished or was aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cal_en_i | input | 1 | Calibration enable; its rising edge starts a run |
| cmp_pu_i | input | 1 | Pull-up comparator bit; 1 means raise the pull-up code |
| cmp_pd_i | input | 1 | Pull-down comparator bit; 1 means raise the pull-down code |
| pu_code_o | output | 6 | Pull-up impedance code |
| pd_code_o | output | 6 | Pull-down impedance code |
| ref_sel_o | output | 1 | 1 while the pull-down comparison is active |
| done_o | output | 1 | Both codes calibrated and frozen |

## Verification
A wrong decision phase shows within four clocks: a code steps on an edge that is not a multiple of four from the start. A faulty alternation count or step direction moves the frozen codes off the dither point that the threshold comparator models predict. It also shifts the cycle at which `done_o` rises, and each run checks that cycle exactly. A broken phase handover shows up on `ref_sel_o` and on the pull-up code, checked at the settle edge. A leaky hold shows up as code drift while the comparators toggle after done or after an abort.

// File: rtl/imp_cal_pkg.sv
package imp_cal_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PU   = 2'd1,
    PH_PD   = 2'd2,
    PH_DONE = 2'd3
  } cal_phase_e;
endpackage

// File: rtl/imp_cal_tick.sv
module imp_cal_tick #(
  parameter int SAMPLE_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (SAMPLE_DIV <= 1) begin : g_every
      assign tick_o = run_i;
    end else begin : g_div
      localparam int CNT_W = $clog2(SAMPLE_DIV);
      localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_DIV - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       cnt_q <= '0;
        else if (clear_i)  cnt_q <= '0;
        else if (run_i)    cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      end

      assign tick_o = run_i && (cnt_q == CNT_LAST);

      // R3: decisions never on back-to-back clocks
      a_r3_tick_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
      a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_LAST);
    end
  endgenerate
endmodule

// File: rtl/imp_cal_loop.sv
module imp_cal_loop #(
  parameter int CODE_W   = 6,
  parameter int DITHER_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] code_o,
  output logic              settled_o
);
  localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam int ALT_W = $clog2(DITHER_N + 1);
  localparam logic [ALT_W-1:0] ALT_HIT = ALT_W'(DITHER_N);

  logic [CODE_W-1:0] code_q, code_next;
  logic [ALT_W-1:0]  alt_q, alt_next;
  logic              last_q, seen_q;

  always_comb begin
    alt_next = (seen_q && (cmp_i != last_q)) ? alt_q + 1'b1 : '0;
    if (cmp_i) code_next = (code_q == CODE_MAX) ? code_q : code_q + 1'b1;
    else       code_next = (code_q == '0)       ? code_q : code_q - 1'b1;
  end

  assign settled_o = step_i && (alt_next == ALT_HIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_MID;
      alt_q  <= '0;
      last_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (clear_i) begin
      code_q <= CODE_MID;
      alt_q  <= '0;
      last_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (step_i) begin
      seen_q <= 1'b1;
      last_q <= cmp_i;
      if (settled_o) begin
        alt_q <= '0;
      end else begin
        alt_q  <= alt_next;
        code_q <= code_next;
      end
    end
  end

  assign code_o = code_q;

  // R4: one step at most per decision
  a_r4_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ($stable(code_q) ||
                  ({1'b0, $past(code_q)} + 1'b1 == {1'b0, code_q}) ||
                  ({1'b0, code_q} + 1'b1 == {1'b0, $past(code_q)})));
  // R3: code moves only on a decision or a reload
  a_r3_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> $stable(code_q));
  // R4: saturation at both ends
  a_r4_sat_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cmp_i && !clear_i && code_q == CODE_MAX) |=> code_q == CODE_MAX);
  a_r4_sat_bottom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !cmp_i && !clear_i && code_q == '0) |=> code_q == '0);
  // R5: settling decision freezes the code
  a_r5_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled_o && !clear_i) |=> $stable(code_q));
endmodule

// File: rtl/imp_cal_seq.sv
module imp_cal_seq
  import imp_cal_pkg::*;
#(
  parameter int CODE_W     = 6,
  parameter int SAMPLE_DIV = 4,
  parameter int DITHER_N   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_en_i,
  input  logic              cmp_pu_i,
  input  logic              cmp_pd_i,
  output logic [CODE_W-1:0] pu_code_o,
  output logic [CODE_W-1:0] pd_code_o,
  output logic              ref_sel_o,
  output logic              done_o
);
  cal_phase_e phase_q;
  logic en_q, start, tick, running;
  logic pu_step, pd_step, pu_settled, pd_settled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= cal_en_i;
  end

  assign start   = cal_en_i && !en_q;
  assign running = (phase_q == PH_PU) || (phase_q == PH_PD);
  assign pu_step = tick && cal_en_i && (phase_q == PH_PU);
  assign pd_step = tick && cal_en_i && (phase_q == PH_PD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              phase_q <= PH_IDLE;
    else if (!cal_en_i)                       phase_q <= PH_IDLE;
    else if (start)                           phase_q <= PH_PU;
    else if (phase_q == PH_PU && pu_settled)  phase_q <= PH_PD;
    else if (phase_q == PH_PD && pd_settled)  phase_q <= PH_DONE;
  end

  imp_cal_tick #(.SAMPLE_DIV(SAMPLE_DIV)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start || pu_settled),
    .run_i   (running),
    .tick_o  (tick)
  );

  imp_cal_loop #(.CODE_W(CODE_W), .DITHER_N(DITHER_N)) u_pu_loop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start),
    .step_i    (pu_step),
    .cmp_i     (cmp_pu_i),
    .code_o    (pu_code_o),
    .settled_o (pu_settled)
  );

  imp_cal_loop #(.CODE_W(CODE_W), .DITHER_N(DITHER_N)) u_pd_loop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start || pu_settled),
    .step_i    (pd_step),
    .cmp_i     (cmp_pd_i),
    .code_o    (pd_code_o),
    .settled_o (pd_settled)
  );

  assign ref_sel_o = (phase_q == PH_PD);
  assign done_o    = (phase_q == PH_DONE);

  // R8: enable low forces idle on the next edge
  a_r8_done_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cal_en_i |=> (!done_o && !ref_sel_o));
  // R6: pull-up code frozen during pull-down phase
  a_r6_pu_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PD && !start) |=> $stable(pu_code_o));
  // R7: codes hold once done
  a_r7_hold_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cal_en_i) |=> ($stable(pu_code_o) && $stable(pd_code_o)));
  a_r7_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ref_sel_o, done_o}));
  // R2: start reloads mid-scale
  a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (pu_code_o == (CODE_W'(1) << (CODE_W - 1)) && !ref_sel_o));
endmodule

// File: tb/tb_imp_cal_seq.sv
module tb_imp_cal_seq;
  localparam int MID = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_en = 1'b0;
  logic cmp_pu, cmp_pd;
  logic [5:0] pu_code, pd_code;
  logic ref_sel, done;

  int pu_tgt = MID;
  int pd_delta = 0;
  int cyc = 0;
  int t0 = 0;
  int checks = 0;
  int errors = 0;

  typedef struct { int pu; int pd; int lat; } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // threshold models of the analog comparators
  assign cmp_pu = int'(pu_code) < pu_tgt;
  assign cmp_pd = int'(pd_code) < (int'(pu_code) + pd_delta);

  imp_cal_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cal_en_i(cal_en),
    .cmp_pu_i(cmp_pu), .cmp_pd_i(cmp_pd),
    .pu_code_o(pu_code), .pd_code_o(pd_code),
    .ref_sel_o(ref_sel), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // frozen value and decision count for a target where cmp=1 below it
  function automatic int fin(input int t);
    return (t > MID) ? t - 1 : t;
  endfunction
  function automatic int ndec(input int t);
    return (t > MID) ? (t - MID + 4) : (MID + 1 - t + 4);
  endfunction

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic lower_en();
    @(negedge clk);
    cal_en = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R8 done cleared", int'(done), 0);
    chk(ref_sel == 1'b0, "R8 ref_sel idle", int'(ref_sel), 0);
  endtask

  task automatic start_run(input int tpu, input int dpd);
    pu_tgt = tpu;
    pd_delta = dpd;
    @(negedge clk);
    cal_en = 1'b1;
    t0 = cyc + 1;
    @(negedge clk);
    chk(pu_code == 6'd32, "R2 pu reload", int'(pu_code), MID);
    chk(pd_code == 6'd32, "R2 pd reload", int'(pd_code), MID);
    chk(ref_sel == 1'b0, "R2 ref_sel in pull-up", int'(ref_sel), 0);
  endtask

  // driver: full calibration run, pushes the expected result
  task automatic run_cal(input int tpu, input int dpd);
    exp_t e;
    int npu, pdt;
    npu = ndec(tpu);
    pdt = fin(tpu) + dpd;
    e.pu = fin(tpu);
    e.pd = fin(pdt);
    e.lat = 4 * (npu + ndec(pdt));
    sb_q.push_back(e);
    start_run(tpu, dpd);
    wait_until(t0 + 4 * npu);
    chk(ref_sel == 1'b1, "R6 ref_sel at handover", int'(ref_sel), 1);
    chk(int'(pu_code) == e.pu, "R6 pu frozen at handover", int'(pu_code), e.pu);
    wait_until(t0 + e.lat + 1);
    chk(done == 1'b1, "R7 done raised", int'(done), 1);
  endtask

  // monitor: decision timing and scoreboard compare
  logic done_d = 1'b0;
  logic [5:0] pu_d = 6'd32, pd_d = 6'd32;
  always @(negedge clk) begin
    if (rst_n && cal_en && cyc > t0) begin
      if (pu_code != pu_d)
        chk(((cyc - t0) % 4) == 0, "R3 pu step phase", (cyc - t0) % 4, 0);
      if (pd_code != pd_d)
        chk(((cyc - t0) % 4) == 0, "R3 pd step phase", (cyc - t0) % 4, 0);
    end
    if (done && !done_d) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(int'(pu_code) == e.pu, "R5 pu final", int'(pu_code), e.pu);
        chk(int'(pd_code) == e.pd, "R6 pd final", int'(pd_code), e.pd);
        chk((cyc - t0) == e.lat, "R5 settle latency", cyc - t0, e.lat);
        chk(ref_sel == 1'b0, "R7 ref_sel after done", int'(ref_sel), 0);
      end
    end
    done_d <= done;
    pu_d <= pu_code;
    pd_d <= pd_code;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] hp, hd;
    repeat (3) @(negedge clk);
    chk(pu_code == 6'd32, "R1 pu reset", int'(pu_code), MID);
    chk(pd_code == 6'd32, "R1 pd reset", int'(pd_code), MID);
    chk(done == 1'b0, "R1 done reset", int'(done), 0);
    chk(ref_sel == 1'b0, "R1 ref_sel reset", int'(ref_sel), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_cal(40, 3);
    // R7: comparators toggle after done, codes must hold
    hp = pu_code; hd = pd_code;
    pu_tgt = 5; pd_delta = 30;
    repeat (40) @(negedge clk);
    chk(pu_code == hp, "R7 pu held after done", int'(pu_code), int'(hp));
    chk(pd_code == hd, "R7 pd held after done", int'(pd_code), int'(hd));
    chk(done == 1'b1, "R7 done held", int'(done), 1);
    lower_en();

    run_cal(20, -5);
    lower_en();
    run_cal(33, 0);
    lower_en();
    run_cal(60, 2);
    lower_en();
    run_cal(10, 20);
    lower_en();

    // R4: upper saturation, loop never settles
    start_run(64, 0);
    wait_until(t0 + 4 * 40 + 1);
    chk(pu_code == 6'd63, "R4 saturate high", int'(pu_code), 63);
    chk(ref_sel == 1'b0, "R4 no settle at top", int'(ref_sel), 0);
    lower_en();
    // R4: lower saturation
    start_run(0, 0);
    wait_until(t0 + 4 * 40 + 1);
    chk(pu_code == 6'd0, "R4 saturate low", int'(pu_code), 0);
    lower_en();

    // R8/R9: abort mid-run, codes hold, then full restart
    start_run(50, 0);
    wait_until(t0 + 30);
    @(negedge clk);
    cal_en = 1'b0;
    @(negedge clk);
    hp = pu_code; hd = pd_code;
    pu_tgt = 3;
    repeat (20) @(negedge clk);
    chk(pu_code == hp, "R8 pu held when disabled", int'(pu_code), int'(hp));
    chk(pd_code == hd, "R8 pd held when disabled", int'(pd_code), int'(hd));
    chk(done == 1'b0, "R8 done low when disabled", int'(done), 0);
    run_cal(50, -7);   // R9 restart from mid-scale
    lower_en();

    repeat (5) @(negedge clk);
    chk(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule